// File: doc/BRIEF.md
# Sector Marker Sequence Checker

This block confirms that a five-sector audio transfer has come through a downstream decryption stage intact. Each sector carries a one-byte marker at the start of its reserved area, holding that sector's ordinal. The decryption stage raises a completion interrupt for each sector. On each interrupt the checker reads the marker byte through a simple register read port and compares it with the ordinal it expects next.

A start pulse arms the check. The block waits for each sector interrupt in turn, guarded by a programmable cycle-count watchdog. It stops at the first fault, or once the last sector matches. The outcome is latched: a pass flag, or an error code together with the index of the failing sector. Software reruns the whole check by pulsing start again, for example after a mismatch. Producing the sector data and decrypting it are outside this block.

Top module: `sector_marker_checker`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, pass and rd_req are 0, and err_code and err_sector are 0.
- R2: A start pulse taken while busy is 0 makes busy 1 in the next cycle. It clears done, pass, err_code and err_sector and begins again at sector 0.
- R3: A sector interrupt that arrives while the block waits for one produces, in the next cycle, a read request exactly one cycle wide with rd_addr equal to the HEAD_ADDR parameter (default 0).
- R4: The byte returned with rd_valid for sector k (k = 0..4) must equal k. A match advances to the next sector.
- R5: When sector 4 matches, busy drops and done and pass rise in the next cycle, with err_code 0.
- R6: A returned byte that differs from the sector ordinal ends the check with err_code 8'd5, err_sector set to that sector, done 1 and pass 0.
- R7: Let T be the value of timeout_cycles (T ≥ 1). An interrupt sampled on any of the first T rising edges after the wait begins is accepted. If none has come by the T-th edge, the check ends at that edge with err_code 8'd22 and err_sector set to the waiting sector.
- R8: The watchdog starts counting from zero at each start and again after each matched sector. Total run time may therefore exceed T, provided that each single gap stays within T.
- R9: While busy, start has no effect. An interrupt that arrives while a read is outstanding has no effect.
- R10: After a run ends, done, pass, err_code and err_sector hold their values until the next start, whatever the interrupt and read-data inputs do. A new start reruns the check from sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start or retry pulse |
| timeout_cycles | input | TW | Watchdog limit in cycles per sector wait |
| sec_irq | input | 1 | Per-sector completion interrupt |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | AW | Register address of the marker byte |
| rd_data | input | DW | Read-back data |
| rd_valid | input | 1 | Read-back data valid |
| busy | output | 1 | Check in progress |
| done | output | 1 | Check finished |
| pass | output | 1 | All sectors matched |
| err_code | output | 8 | 0 none, 5 mismatch, 22 missing interrupt |
| err_sector | output | SW | Sector index of the fault |

## Verification
The bench targets the watchdog boundary. An interrupt on the T-th edge must be accepted and one on the edge after it must not. A block that is off by one would either report 22 on a good run or accept a late sector. Gap sequences whose sum exceeds T catch a watchdog that never restarts between sectors. A start pulse in the middle of a run, and an extra interrupt while a read is pending, expose a design that restarts or skips a sector: such a design would report a false mismatch. Mismatches at every sector position, a retry after a failure, and garbage inputs after the end check that the fault index is right and that the result stays latched.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_IRQ = 2'd1,
    ST_WAIT_RD  = 2'd2,
    ST_END      = 2'd3
  } smc_state_e;

  localparam logic [7:0] ERR_NONE     = 8'd0;
  localparam logic [7:0] ERR_MISMATCH = 8'd5;
  localparam logic [7:0] ERR_NO_IRQ   = 8'd22;
endpackage

// File: rtl/smc_watchdog.sv
module smc_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
  assign expired  = run && (next_cnt >= {1'b0, limit});

  // counter is held at zero whenever the wait is not active
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= next_cnt[TW-1:0];
    end
  end
endmodule

// File: rtl/smc_compare.sv
module smc_compare #(
  parameter int DW = 8,
  parameter int SW = 3,
  parameter int NUM_SECTORS = 5
) (
  input  logic [DW-1:0] rd_data,
  input  logic [SW-1:0] sector,
  output logic          match,
  output logic          last
);
  localparam logic [SW-1:0] LAST_IDX = SW'(NUM_SECTORS - 1);
  logic [DW-1:0] expected;

  generate
    if (DW > SW) begin : g_wide
      assign expected = {{(DW-SW){1'b0}}, sector};
    end else begin : g_narrow
      assign expected = sector[DW-1:0];
    end
  endgenerate

  assign match = (rd_data == expected);
  assign last  = (sector == LAST_IDX);
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int            AW = 8,
  parameter int            SW = 3,
  parameter logic [AW-1:0] HEAD_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sec_irq,
  input  logic          rd_valid,
  input  logic          match,
  input  logic          last,
  input  logic          wd_expired,
  output logic          wd_run,
  output logic [SW-1:0] sector,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [7:0]    err_code,
  output logic [SW-1:0] err_sector
);
  smc_state_e state_q;

  assign wd_run = (state_q == ST_WAIT_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sector     <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      err_code   <= ERR_NONE;
      err_sector <= '0;
    end else begin
      rd_req <= 1'b0;
      case (state_q)
        ST_IDLE, ST_END: begin
          if (start) begin
            state_q    <= ST_WAIT_IRQ;
            sector     <= '0;
            busy       <= 1'b1;
            done       <= 1'b0;
            pass       <= 1'b0;
            err_code   <= ERR_NONE;
            err_sector <= '0;
          end
        end
        ST_WAIT_IRQ: begin
          if (sec_irq) begin
            rd_req  <= 1'b1;
            rd_addr <= HEAD_ADDR;
            state_q <= ST_WAIT_RD;
          end else if (wd_expired) begin
            err_code   <= ERR_NO_IRQ;
            err_sector <= sector;
            busy       <= 1'b0;
            done       <= 1'b1;
            state_q    <= ST_END;
          end
        end
        ST_WAIT_RD: begin
          if (rd_valid) begin
            if (!match) begin
              err_code   <= ERR_MISMATCH;
              err_sector <= sector;
              busy       <= 1'b0;
              done       <= 1'b1;
              state_q    <= ST_END;
            end else if (last) begin
              pass    <= 1'b1;
              busy    <= 1'b0;
              done    <= 1'b1;
              state_q <= ST_END;
            end else begin
              sector  <= sector + 1'b1;
              state_q <= ST_WAIT_IRQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_marker_checker.sv
module sector_marker_checker #(
  parameter int            NUM_SECTORS = 5,
  parameter int            DW = 8,
  parameter int            AW = 8,
  parameter int            TW = 16,
  parameter logic [AW-1:0] HEAD_ADDR = '0,
  localparam int           SW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] timeout_cycles,
  input  logic          sec_irq,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [7:0]    err_code,
  output logic [SW-1:0] err_sector
);
  logic          wd_run;
  logic          wd_expired;
  logic          match;
  logic          last;
  logic [SW-1:0] sector;

  smc_watchdog #(.TW(TW)) u_wd (
    .clk     (clk),
    .rst     (rst),
    .run     (wd_run),
    .limit   (timeout_cycles),
    .expired (wd_expired)
  );

  smc_compare #(.DW(DW), .SW(SW), .NUM_SECTORS(NUM_SECTORS)) u_cmp (
    .rd_data (rd_data),
    .sector  (sector),
    .match   (match),
    .last    (last)
  );

  smc_ctrl #(.AW(AW), .SW(SW), .HEAD_ADDR(HEAD_ADDR)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sec_irq    (sec_irq),
    .rd_valid   (rd_valid),
    .match      (match),
    .last       (last),
    .wd_expired (wd_expired),
    .wd_run     (wd_run),
    .sector     (sector),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .err_code   (err_code),
    .err_sector (err_sector)
  );
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          rd_req,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [7:0]    err_code,
  input logic [SW-1:0] err_sector
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !pass && !rd_req && err_code == 8'd0));

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && !pass && err_code == 8'd0));

  // R3
  rdreq_pulse_chk: assert property (@(posedge clk) disable iff (rst) rd_req |=> !rd_req);

  // R3
  rdreq_busy_chk: assert property (@(posedge clk) disable iff (rst) rd_req |-> busy);

  // R5
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst) pass |-> (done && err_code == 8'd0));

  // R6
  err_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code == 8'd0) || ((err_code == 8'd5 || err_code == 8'd22) && done && !pass));

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(err_code) && $stable(err_sector) && $stable(pass) && done));
endmodule

bind sector_marker_checker smc_checker #(.SW(SW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .rd_req     (rd_req),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .err_code   (err_code),
  .err_sector (err_sector)
);

// File: tb/sector_marker_checker_tb.sv
`timescale 1ns/1ps
module sector_marker_checker_tb;
  localparam int TW = 16;
  localparam logic [7:0] HEAD = 8'h00;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [TW-1:0] timeout_cycles = 16'd8;
  logic          sec_irq = 1'b0;
  logic          rd_req;
  logic [7:0]    rd_addr;
  logic [7:0]    rd_data = 8'h00;
  logic          rd_valid = 1'b0;
  logic          busy, done, pass;
  logic [7:0]    err_code;
  logic [2:0]    err_sector;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sector_marker_checker u_dut (
    .clk(clk), .rst(rst), .start(start), .timeout_cycles(timeout_cycles),
    .sec_irq(sec_irq), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .pass(pass),
    .err_code(err_code), .err_sector(err_sector)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(input int T, input int hb[5], input int gap[5]);
    for (int i = 0; i < 5; i++) begin
      if (gap[i] > T) return 22;
      if (hb[i] != i) return 5;
    end
    return 0;
  endfunction

  function automatic int exp_index(input int T, input int hb[5], input int gap[5]);
    for (int i = 0; i < 5; i++) begin
      if (gap[i] > T || hb[i] != i) return i;
    end
    return 0;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit && !done; k++) @(negedge clk);
  endtask

  task automatic run_seq(input int T, input int hb[5], input int gap[5], input int lat,
                         input bit mid_start, input bit extra_irq, input string tag);
    int ec;
    int es;
    ec = exp_code(T, hb, gap);
    es = exp_index(T, hb, gap);
    timeout_cycles = TW'(T);
    pulse_start();
    chk(busy === 1'b1 && done === 1'b0, "R2", {tag, " busy after start"}, int'(busy), 1);
    for (int i = 0; i < 5; i++) begin
      if (gap[i] > T) break;
      repeat (gap[i] - 1) @(negedge clk);
      sec_irq = 1'b1;
      if (mid_start && i == 2) start = 1'b1;
      @(negedge clk);
      sec_irq = 1'b0;
      start = 1'b0;
      chk(rd_req === 1'b1, "R3", {tag, " read request"}, int'(rd_req), 1);
      chk(rd_addr === HEAD, "R3", {tag, " read address"}, int'(rd_addr), int'(HEAD));
      if (extra_irq) sec_irq = 1'b1;
      @(negedge clk);
      sec_irq = 1'b0;
      chk(rd_req === 1'b0, "R3", {tag, " request one cycle"}, int'(rd_req), 0);
      repeat (lat - 1) @(negedge clk);
      rd_valid = 1'b1;
      rd_data = 8'(hb[i]);
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data = 8'h00;
      if (hb[i] != i) break;
    end
    wait_done(4 * T + 40);
    chk(done === 1'b1 && busy === 1'b0, "R5", {tag, " finished"}, int'(done), 1);
    chk(err_code === 8'(ec), ec == 22 ? "R7" : (ec == 5 ? "R6" : "R4"), {tag, " err_code"}, int'(err_code), ec);
    chk(pass === (ec == 0), "R5", {tag, " pass flag"}, int'(pass), int'(ec == 0));
    if (ec != 0) chk(err_sector === 3'(es), "R6", {tag, " err_sector"}, int'(err_sector), es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    int hb[5];
    int gp[5];
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && pass === 0 && rd_req === 0, "R1", "outputs in reset", int'(busy | done | pass | rd_req), 0);
    chk(err_code === 8'd0 && err_sector === 3'd0, "R1", "codes in reset", int'(err_code), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R1", "idle after reset", int'(busy), 0);

    // R4 R5 clean run, fast sectors
    hb = '{0, 1, 2, 3, 4}; gp = '{1, 1, 1, 1, 1};
    run_seq(8, hb, gp, 1, 0, 0, "R5 fast");
    // R8 each gap at the limit, sum far above T
    gp = '{6, 6, 6, 6, 6};
    run_seq(6, hb, gp, 3, 0, 0, "R8 gaps at limit");
    // R7 one beyond the limit at sector 3
    gp = '{6, 6, 6, 7, 6};
    run_seq(6, hb, gp, 2, 0, 0, "R7 late sector 3");
    // R6 mismatch at first and last sector
    hb = '{9, 1, 2, 3, 4}; gp = '{2, 2, 2, 2, 2};
    run_seq(8, hb, gp, 2, 0, 0, "R6 sector 0");
    hb = '{0, 1, 2, 3, 0};
    run_seq(8, hb, gp, 1, 0, 0, "R6 sector 4");
    // R10 retry after mismatch reruns from sector 0
    hb = '{0, 1, 2, 3, 4};
    run_seq(8, hb, gp, 1, 0, 0, "R10 retry");
    // R9 start while busy and interrupt during read are ignored
    run_seq(8, hb, gp, 3, 1, 0, "R9 start busy");
    run_seq(8, hb, gp, 3, 0, 1, "R9 irq in read");

    // R7 exact timing of the missing interrupt at sector 0
    timeout_cycles = 16'd5;
    pulse_start();
    repeat (4) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R7", "still waiting at T-1", int'(done), 0);
    @(negedge clk);
    chk(done === 1'b1 && err_code === 8'd22, "R7", "timeout at T", int'(err_code), 22);
    chk(err_sector === 3'd0, "R7", "timeout sector", int'(err_sector), 0);
    // R10 results hold against stray inputs
    sec_irq = 1'b1; rd_valid = 1'b1; rd_data = 8'h03;
    repeat (3) @(negedge clk);
    sec_irq = 1'b0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && err_code === 8'd22 && rd_req === 1'b0, "R10", "result held", int'(err_code), 22);

    // random runs
    for (int r = 0; r < 40; r++) begin
      int T;
      T = 3 + int'($urandom % 10);
      for (int i = 0; i < 5; i++) begin
        hb[i] = ($urandom % 8 == 0) ? i + 1 + int'($urandom % 200) : i;
        gp[i] = ($urandom % 10 == 0) ? T + 1 : 1 + int'($urandom % T);
      end
      run_seq(T, hb, gp, 1 + int'($urandom % 4), 0, 0, "R4 random");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule